// File: doc/BRIEF.md
# Consecutive-ones run detector

This block watches a single serial bit and raises its output in any clock cycle where that bit has been 1 for a configurable number of consecutive cycles, counting the current one. The output is a Mealy output. It is formed combinationally from the live input and the stored state, so it rises in the same cycle as the qualifying input bit and falls in the same cycle the input drops.

The block does not keep a shift history of recent inputs. It keeps a saturating count of the 1s seen since the last 0. The register therefore needs only about log2 of the run length in bits, so a threshold such as 25 costs five flip-flops. The parameter `RUN_LEN` sets the threshold. Its default is 3.

Top module: `run_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the stored run is cleared. After reset, `hit` is 0 until `RUN_LEN` ones have arrived.
- R2: `hit` is 1 in a cycle exactly when `din` is 1 in that cycle and was also 1 in each of the preceding `RUN_LEN`-1 cycles since reset.
- R3: A 0 on `din` in any state returns the detector to the no-ones state, and `hit` is 0 in that cycle. A following run must again reach `RUN_LEN` ones before `hit` rises.
- R4: During an unbroken run of 1s, `hit` stays 1 on every cycle from the `RUN_LEN`-th 1 onward, with no upper limit on the run length.
- R5: `hit` is a Mealy output. It changes in the same cycle as `din`, with no extra register stage.
- R6: The run count saturates at `RUN_LEN`-1 and is held in ceil(log2(`RUN_LEN`)) bits, so large thresholds such as 25 work.
- R7: With `RUN_LEN` = 1, `hit` equals `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit |
| hit | output | 1 | High while the current run of 1s has reached `RUN_LEN` |

## Verification
The assertions check several rules on every cycle:
- a 0 empties the count;
- the count steps up by one on each 1 until it reaches `RUN_LEN`-1 and never goes beyond it;
- reset clears the count;
- once `hit` is high, it stays high for as long as `din` stays 1.

Only the bench's scenarios can show other properties. These include the exact cycle in which `hit` first rises, its same-cycle reaction to `din`, and correct behaviour across thresholds of 1, 3 and 25. The bench covers these with a run-length model that it compares against all three instances on every clock.

// File: rtl/run_detector.sv
module run_detector #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] TOP = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt;
  logic          full;

  assign full = (cnt == TOP);
  assign hit  = din & full;

  always_ff @(posedge clk) begin
    if (rst || !din)
      cnt <= '0;
    else if (!full)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/run_detector_chk.sv
module run_detector_chk #(
  parameter int RUN_LEN = 3,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          din,
  input logic          hit,
  input logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] TOP = CW'(RUN_LEN - 1);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> cnt == '0);

  // R3
  zero_empties_chk: assert property (@(posedge clk) disable iff (rst) !din |=> cnt == '0);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (din && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (din && cnt == TOP) |=> cnt == TOP);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= TOP);

  // R4
  hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (din -> hit));

  // R2
  hit_needs_one_chk: assert property (@(posedge clk) disable iff (rst) hit |-> din);

endmodule

bind run_detector run_detector_chk #(.RUN_LEN(RUN_LEN), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .din(din), .hit(hit), .cnt(cnt)
);

// File: tb/run_detector_test.sv
module run_detector_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit3, hit25, hit1;

  int checks = 0;
  int errors = 0;
  int run = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  run_detector uut (.clk(clk), .rst(rst), .din(din), .hit(hit3));
  run_detector #(.RUN_LEN(25)) uut_long (.clk(clk), .rst(rst), .din(din), .hit(hit25));
  run_detector #(.RUN_LEN(1)) uut_one (.clk(clk), .rst(rst), .din(din), .hit(hit1));

  task automatic compare(input logic got, input logic exp, input string who);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (run=%0d)", tag, who, got, exp, run);
    end
  endtask

  // drive one cycle, check mid-cycle, then advance the model
  task automatic cycle(input logic v);
    @(negedge clk);
    din = v;
    #5;
    compare(hit3,  din && (run + 1 >= 3),  "N=3");
    compare(hit25, din && (run + 1 >= 25), "N=25 R6");
    compare(hit1,  din, "N=1 R7");
    if (rst || !din) run = 0;
    else run = run + 1;
  endtask

  initial begin
    tag = "R1";
    rst = 1'b1;
    repeat (3) cycle(1'b0);
    rst = 1'b0;
    // R1: a partial run after reset does not fire
    cycle(1'b1); cycle(1'b1); cycle(1'b0);
    // R2: exact threshold
    tag = "R2";
    cycle(1'b1); cycle(1'b1); cycle(1'b1); cycle(1'b0);
    // R3: runs broken by zeros
    tag = "R3";
    cycle(1'b1); cycle(1'b1); cycle(1'b0); cycle(1'b1); cycle(1'b0);
    cycle(1'b1); cycle(1'b1); cycle(1'b1); cycle(1'b1); cycle(1'b0);
    // R4 / R6: long run crosses 25 and stays high
    tag = "R4";
    for (int i = 0; i < 40; i++) cycle(1'b1);
    // R5: same-cycle drop and re-entry
    tag = "R5";
    cycle(1'b0); cycle(1'b1); cycle(1'b0); cycle(1'b1);
    // R6: 24 ones then a zero must not fire the long instance
    tag = "R6";
    cycle(1'b0);
    for (int i = 0; i < 24; i++) cycle(1'b1);
    cycle(1'b0);
    for (int i = 0; i < 26; i++) cycle(1'b1);
    // R1: reset in mid-run clears the count
    tag = "R1";
    rst = 1'b1;
    cycle(1'b0);
    rst = 1'b0;
    cycle(1'b1); cycle(1'b1); cycle(1'b1);
    // R7: alternating pattern
    tag = "R7";
    for (int i = 0; i < 10; i++) cycle(logic'(i % 2));
    for (int i = 0; i < 60; i++) cycle(logic'((i * 7 + i / 5) % 3 != 0));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule